// File: doc/BRIEF.md
# Valley-Skipping Switch-On Controller

This block decides when the main power switch of a quasi-resonant flyback converter turns on, and it holds the switch on for a bounded time. Across each long evaluation window it records the highest feedback region that the three digital feedback comparator flags report. At the end of the window it moves a saturating valley target between 1 and 7. A light load makes the target rise, so the switch skips more valleys. A heavy load makes it fall, and a sudden overload sends it straight back to 1.

While the switch is off, the block counts the zero-crossing pulses it receives. It allows a turn-on only after a ringing blank has expired, and the length of that blank depends on the ringing-level flag. The switch turns on once the count reaches the target. If the count never gets there, the switch turns on anyway when the off time reaches its limit. While the switch is on, the digital turn-off request from the current comparator is masked until a minimum on time has passed, and a maximum on time forces the switch off.

All time limits are cycle counts of the system clock and are set by parameters.

Top module: `valleySwitchCtrl`

## Requirements
- R1: Reset state: after reset the gate output is low, the valley target is 1 and the zero-crossing count is 0.
- R2: At a window end, if all three feedback flags stayed low for the whole window, the target rises by 1, and it stays at 7 once it is there.
- R3: At a window end, if the low-threshold flag was seen high but the high-threshold flag never was, the target keeps its value.
- R4: At a window end, if the high-threshold flag was seen high but the reset-threshold flag never was, the target falls by 1, and it stays at 1 once it is there.
- R5: At a window end, if the reset-threshold flag was high in any cycle of that window, the target becomes 1. The decision uses the highest region reached at any point in the window, including a single-cycle excursion.
- R6: The zero-crossing count adds one for each cycle in which the crossing pulse is high while the gate is low, and it saturates at 7. The pulse has no effect while the gate is high. The count reads 0 from the cycle the gate goes high.
- R7: After the gate falls, it stays low for at least RS_SHORT cycles when the ringing flag is high and at least RS_LONG cycles when the ringing flag is low.
- R8: Once the blank has passed, the gate rises on the clock edge that follows the first cycle in which the zero-crossing count is at least the target.
- R9: If the count stays below the target, the gate rises after exactly MAX_OFF cycles low.
- R10: A turn-off request has no effect during the first LEB cycles of a high phase. A request that is held from the start gives a high phase of exactly LEB cycles.
- R11: A turn-off request that is first seen in high cycle k, with k counted from 0 and k at least LEB-1, ends the high phase after k+1 cycles.
- R12: Without a turn-off request, the gate stays high for exactly MAX_ON cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| fbAboveLow | input | 1 | Feedback is above the low threshold |
| fbAboveHigh | input | 1 | Feedback is above the high threshold |
| fbAboveReset | input | 1 | Feedback is above the reset threshold |
| zcPulse | input | 1 | One-cycle pulse for each falling zero crossing |
| ringHigh | input | 1 | Zero-crossing level is above the ringing threshold (selects the short blank) |
| offReq | input | 1 | Turn-off request from the current comparator |
| gateOn | output | 1 | Gate drive command |
| valleyTarget | output | $clog2(VALLEY_MAX+1) | Current valley target |
| valleyCount | output | $clog2(VALLEY_MAX+1) | Zero crossings counted in this off phase |

## Verification
The assertions assume that the three feedback flags are nested, so that a higher flag is high only while every lower flag is high. They also assume that the limits are ordered RS_SHORT ≤ RS_LONG < MAX_OFF and LEB < MAX_ON. The bench sets each flag from a single zone number, so the flags are always nested. It uses limit values that keep this ordering, and it gives crossing pulses only one cycle wide.

// File: rtl/vsPkg.sv
package vsPkg;

  // Feedback zone, ordered so that a larger value means a heavier load.
  typedef enum logic [1:0] {
    ZONE_LIGHT = 2'd0,
    ZONE_MID   = 2'd1,
    ZONE_HEAVY = 2'd2,
    ZONE_SURGE = 2'd3
  } fbZone_t;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic turnOn;   // the gate rises at this edge
    logic turnOff;  // the gate falls at this edge
    logic winEnd;   // last cycle of the evaluation window
  } vsStrobe_t;

endpackage

// File: rtl/vsDatapath.sv
module vsDatapath
  import vsPkg::*;
#(
  parameter int MAX_OFF    = 10500,
  parameter int MAX_ON     = 7500,
  parameter int VALLEY_MAX = 7
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  vsStrobe_t                         stb,
  input  logic                              gateOn,
  input  logic                              zcPulse,
  input  logic                              fbAboveLow,
  input  logic                              fbAboveHigh,
  input  logic                              fbAboveReset,
  output logic [$clog2(MAX_ON+1)-1:0]       onTime,
  output logic [$clog2(MAX_OFF+1)-1:0]      offTime,
  output logic [$clog2(VALLEY_MAX+1)-1:0]   zcCount,
  output logic [$clog2(VALLEY_MAX+1)-1:0]   target
);

  localparam int ONW = $clog2(MAX_ON + 1);
  localparam int OFFW = $clog2(MAX_OFF + 1);
  localparam int VW = $clog2(VALLEY_MAX + 1);
  localparam logic [ONW-1:0] ON_SAT = ONW'(MAX_ON - 1);
  localparam logic [OFFW-1:0] OFF_SAT = OFFW'(MAX_OFF - 1);
  localparam logic [VW-1:0] V_TOP = VW'(VALLEY_MAX);
  localparam logic [VW-1:0] V_ONE = VW'(1);

  fbZone_t zoneNow;
  fbZone_t zonePeak;
  fbZone_t zoneMax;

  // The nested comparator flags give one zone number.
  always_comb begin
    if (fbAboveReset)      zoneNow = ZONE_SURGE;
    else if (fbAboveHigh)  zoneNow = ZONE_HEAVY;
    else if (fbAboveLow)   zoneNow = ZONE_MID;
    else                   zoneNow = ZONE_LIGHT;
    zoneMax = (zoneNow > zonePeak) ? zoneNow : zonePeak;
  end

  // Highest zone seen in the window. The current cycle is included through zoneMax.
  always_ff @(posedge clk) begin
    if (!rstN || stb.winEnd) zonePeak <= ZONE_LIGHT;
    else                     zonePeak <= zoneMax;
  end

  // Saturating valley target, updated once per window.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      target <= V_ONE;
    end else if (stb.winEnd) begin
      unique case (zoneMax)
        ZONE_LIGHT: if (target < V_TOP) target <= target + V_ONE;
        ZONE_MID:   target <= target;
        ZONE_HEAVY: if (target > V_ONE) target <= target - V_ONE;
        ZONE_SURGE: target <= V_ONE;
        default:    target <= target;
      endcase
    end
  end

  // Zero-crossing counter for the current off phase.
  always_ff @(posedge clk) begin
    if (!rstN || stb.turnOn) zcCount <= '0;
    else if (!gateOn && zcPulse && zcCount < V_TOP) zcCount <= zcCount + V_ONE;
  end

  // Phase timers. Each restarts at its own edge and saturates at limit-1.
  always_ff @(posedge clk) begin
    if (!rstN || stb.turnOn) onTime <= '0;
    else if (gateOn && onTime < ON_SAT) onTime <= onTime + ONW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.turnOff) offTime <= '0;
    else if (!gateOn && offTime < OFF_SAT) offTime <= offTime + OFFW'(1);
  end

endmodule

// File: rtl/vsControl.sv
module vsControl
  import vsPkg::*;
#(
  parameter int WIN_CYCLES = 12000000,
  parameter int RS_SHORT   = 625,
  parameter int RS_LONG    = 6250,
  parameter int MAX_OFF    = 10500,
  parameter int LEB        = 83,
  parameter int MAX_ON     = 7500,
  parameter int VALLEY_MAX = 7
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              ringHigh,
  input  logic                              offReq,
  input  logic [$clog2(MAX_ON+1)-1:0]       onTime,
  input  logic [$clog2(MAX_OFF+1)-1:0]      offTime,
  input  logic [$clog2(VALLEY_MAX+1)-1:0]   zcCount,
  input  logic [$clog2(VALLEY_MAX+1)-1:0]   target,
  output vsStrobe_t                         stb,
  output logic                              gateOn
);

  localparam int ONW = $clog2(MAX_ON + 1);
  localparam int OFFW = $clog2(MAX_OFF + 1);
  localparam int WW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_CYCLES - 1);
  localparam logic [OFFW-1:0] BLANK_S = OFFW'(RS_SHORT - 1);
  localparam logic [OFFW-1:0] BLANK_L = OFFW'(RS_LONG - 1);
  localparam logic [OFFW-1:0] OFF_LAST = OFFW'(MAX_OFF - 1);
  localparam logic [ONW-1:0] LEB_LAST = ONW'(LEB - 1);
  localparam logic [ONW-1:0] ON_LAST = ONW'(MAX_ON - 1);

  logic [WW-1:0] winCnt;
  logic [OFFW-1:0] blankLast;
  logic blankDone;
  logic valleyHit;

  always_ff @(posedge clk) begin
    if (!rstN || stb.winEnd) winCnt <= '0;
    else                     winCnt <= winCnt + WW'(1);
  end

  // The blank length follows the ringing flag in every cycle.
  always_comb begin
    blankLast = ringHigh ? BLANK_S : BLANK_L;
    blankDone = offTime >= blankLast;
    valleyHit = zcCount >= target;
    stb.winEnd = (winCnt == WIN_LAST);
    stb.turnOn = !gateOn && ((blankDone && valleyHit) || offTime >= OFF_LAST);
    stb.turnOff = gateOn && ((offReq && onTime >= LEB_LAST) || onTime >= ON_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN)            gateOn <= 1'b0;
    else if (stb.turnOn)  gateOn <= 1'b1;
    else if (stb.turnOff) gateOn <= 1'b0;
  end

endmodule

// File: rtl/valleySwitchCtrl.sv
module valleySwitchCtrl
  import vsPkg::*;
#(
  parameter int WIN_CYCLES = 12000000,
  parameter int RS_SHORT   = 625,
  parameter int RS_LONG    = 6250,
  parameter int MAX_OFF    = 10500,
  parameter int LEB        = 83,
  parameter int MAX_ON     = 7500,
  parameter int VALLEY_MAX = 7
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              fbAboveLow,
  input  logic                              fbAboveHigh,
  input  logic                              fbAboveReset,
  input  logic                              zcPulse,
  input  logic                              ringHigh,
  input  logic                              offReq,
  output logic                              gateOn,
  output logic [$clog2(VALLEY_MAX+1)-1:0]   valleyTarget,
  output logic [$clog2(VALLEY_MAX+1)-1:0]   valleyCount
);

  localparam int ONW = $clog2(MAX_ON + 1);
  localparam int OFFW = $clog2(MAX_OFF + 1);

  vsStrobe_t stb;
  logic [ONW-1:0] onTime;
  logic [OFFW-1:0] offTime;

  vsControl #(
    .WIN_CYCLES(WIN_CYCLES), .RS_SHORT(RS_SHORT), .RS_LONG(RS_LONG),
    .MAX_OFF(MAX_OFF), .LEB(LEB), .MAX_ON(MAX_ON), .VALLEY_MAX(VALLEY_MAX)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ringHigh(ringHigh), .offReq(offReq),
    .onTime(onTime), .offTime(offTime), .zcCount(valleyCount),
    .target(valleyTarget), .stb(stb), .gateOn(gateOn)
  );

  vsDatapath #(
    .MAX_OFF(MAX_OFF), .MAX_ON(MAX_ON), .VALLEY_MAX(VALLEY_MAX)
  ) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .gateOn(gateOn), .zcPulse(zcPulse),
    .fbAboveLow(fbAboveLow), .fbAboveHigh(fbAboveHigh),
    .fbAboveReset(fbAboveReset), .onTime(onTime), .offTime(offTime),
    .zcCount(valleyCount), .target(valleyTarget)
  );

endmodule

// File: rtl/valleySwitchCtrlChecker.sv
module valleySwitchCtrlChecker #(
  parameter int RS_SHORT   = 625,
  parameter int MAX_OFF    = 10500,
  parameter int LEB        = 83,
  parameter int MAX_ON     = 7500,
  parameter int VALLEY_MAX = 7
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              gateOn,
  input logic [$clog2(VALLEY_MAX+1)-1:0]   valleyTarget,
  input logic [$clog2(VALLEY_MAX+1)-1:0]   valleyCount
);

  localparam int VW = $clog2(VALLEY_MAX + 1);

  // Lengths of the current high and low phases, kept by the checker itself.
  int highRun;
  int lowRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highRun <= 0;
      lowRun <= 0;
    end else begin
      highRun <= gateOn ? highRun + 1 : 0;
      lowRun <= gateOn ? 0 : lowRun + 1;
    end
  end

  AST_TARGET_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (valleyTarget >= VW'(1)) && (valleyTarget <= VW'(VALLEY_MAX))); // R2

  AST_TARGET_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (valleyTarget != $past(valleyTarget)) |->
      (valleyTarget == VW'(1) || valleyTarget == $past(valleyTarget) + VW'(1)
       || valleyTarget == $past(valleyTarget) - VW'(1))); // R5

  AST_COUNT_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    gateOn |-> (valleyCount == '0)); // R6

  AST_BLANK_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOn) |-> (lowRun >= RS_SHORT)); // R7

  AST_OFF_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    !gateOn |-> (lowRun <= MAX_OFF - 1)); // R9

  AST_ON_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gateOn) |-> (highRun >= LEB)); // R10

  AST_ON_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    gateOn |-> (highRun <= MAX_ON - 1)); // R12

endmodule

bind valleySwitchCtrl valleySwitchCtrlChecker #(
  .RS_SHORT(RS_SHORT), .MAX_OFF(MAX_OFF), .LEB(LEB),
  .MAX_ON(MAX_ON), .VALLEY_MAX(VALLEY_MAX)
) uChk (
  .clk(clk), .rstN(rstN), .gateOn(gateOn),
  .valleyTarget(valleyTarget), .valleyCount(valleyCount)
);

// File: tb/tb_valleySwitchCtrl.sv
module tb_valleySwitchCtrl;

  localparam int WIN = 256;
  localparam int RSS = 4;
  localparam int RSL = 12;
  localparam int MOFF = 30;
  localparam int LEBC = 3;
  localparam int MON = 20;
  localparam int NVEC = 14;

  typedef struct packed {
    logic [1:0] baseZone;
    logic [1:0] spikeZone;
    logic [2:0] expTarget;
  } winVec_t;

  // Zone held for the window, a one-cycle zone in mid-window, and the target expected afterwards.
  localparam winVec_t VECS [NVEC] = '{
    '{2'd0, 2'd0, 3'd2}, // R2
    '{2'd0, 2'd0, 3'd3}, // R2
    '{2'd0, 2'd0, 3'd4}, // R2
    '{2'd0, 2'd0, 3'd5}, // R2
    '{2'd0, 2'd0, 3'd6}, // R2
    '{2'd0, 2'd0, 3'd7}, // R2
    '{2'd0, 2'd0, 3'd7}, // R2 saturation
    '{2'd1, 2'd1, 3'd7}, // R3
    '{2'd0, 2'd2, 3'd6}, // R4 via a one-cycle excursion
    '{2'd2, 2'd2, 3'd5}, // R4
    '{2'd1, 2'd1, 3'd5}, // R3
    '{2'd0, 2'd3, 3'd1}, // R5 one-cycle surge
    '{2'd2, 2'd2, 3'd1}, // R4 floor
    '{2'd0, 2'd0, 3'd2}  // R2
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fbAboveLow = 1'b0;
  logic fbAboveHigh = 1'b0;
  logic fbAboveReset = 1'b0;
  logic zcPulse = 1'b0;
  logic ringHigh = 1'b1;
  logic offReq = 1'b0;
  logic gateOn;
  logic [2:0] valleyTarget;
  logic [2:0] valleyCount;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  valleySwitchCtrl #(
    .WIN_CYCLES(WIN), .RS_SHORT(RSS), .RS_LONG(RSL), .MAX_OFF(MOFF),
    .LEB(LEBC), .MAX_ON(MON), .VALLEY_MAX(7)
  ) dut (
    .clk(clk), .rstN(rstN), .fbAboveLow(fbAboveLow), .fbAboveHigh(fbAboveHigh),
    .fbAboveReset(fbAboveReset), .zcPulse(zcPulse), .ringHigh(ringHigh),
    .offReq(offReq), .gateOn(gateOn), .valleyTarget(valleyTarget),
    .valleyCount(valleyCount)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setZone(input logic [1:0] z);
    fbAboveLow = (z >= 2'd1);
    fbAboveHigh = (z >= 2'd2);
    fbAboveReset = (z == 2'd3);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 gate", int'(gateOn), 0);
    check("R1 target", int'(valleyTarget), 1);
    check("R1 count", int'(valleyCount), 0);
    rstN = 1'b1;
  endtask

  // Called at the negedge of the first low cycle. Returns the number of low cycles.
  task automatic lowPhase(input int p1, input int p2, output int len);
    len = 0;
    while (gateOn == 1'b0 && len < 200) begin
      zcPulse = (len == p1 || len == p2);
      @(posedge clk);
      @(negedge clk);
      zcPulse = 1'b0;
      len++;
    end
  endtask

  // Called at the negedge of the first high cycle. Returns the number of high cycles.
  task automatic highPhase(input int offAt, input bit pulses, output int len);
    len = 0;
    while (gateOn == 1'b1 && len < 200) begin
      offReq = (len >= offAt);
      zcPulse = pulses;
      @(posedge clk);
      @(negedge clk);
      len++;
    end
    offReq = 1'b0;
    zcPulse = 1'b0;
  endtask

  task automatic syncToLow();
    int guard;
    guard = 0;
    while (gateOn == 1'b0 && guard < 200) begin @(posedge clk); @(negedge clk); guard++; end
    while (gateOn == 1'b1 && guard < 400) begin @(posedge clk); @(negedge clk); guard++; end
  endtask

  initial begin
    int len;
    doReset();
    // Window vectors, aligned with the window that starts at reset release.
    for (int i = 0; i < NVEC; i++) begin
      for (int c = 0; c < WIN; c++) begin
        if (c == WIN / 2) setZone(VECS[i].spikeZone);
        else setZone(VECS[i].baseZone);
        @(posedge clk);
        @(negedge clk);
      end
      check("R2-R5 window target", int'(valleyTarget), int'(VECS[i].expTarget));
    end

    // Target now 2. The feedback zone is held in the middle band, so the target holds.
    setZone(2'd1);
    ringHigh = 1'b1;
    syncToLow();
    lowPhase(0, 5, len);
    check("R8 second crossing at cycle 5", len, 7);
    check("R6 cleared at rise", int'(valleyCount), 0);
    highPhase(1000, 1'b0, len);
    check("R12 max on", len, MON);
    lowPhase(0, 1, len);
    check("R7 short blank", len, RSS);
    highPhase(1000, 1'b0, len);
    lowPhase(0, -1, len);
    check("R9 max off, one crossing below target", len, MOFF);

    // Fresh reset: target 1.
    @(negedge clk);
    doReset();
    lowPhase(-1, -1, len);
    check("R9 max off from reset", len, MOFF);
    highPhase(0, 1'b0, len);
    check("R10 request held from start", len, LEBC);
    lowPhase(0, -1, len);
    check("R7 short blank", len, RSS);
    highPhase(6, 1'b0, len);
    check("R11 request at cycle 6", len, 7);
    ringHigh = 1'b0;
    lowPhase(0, -1, len);
    check("R7 long blank", len, RSL);
    ringHigh = 1'b1;
    highPhase(0, 1'b1, len);
    check("R10 min on with pulses", len, LEBC);
    check("R6 pulses ignored while high", int'(valleyCount), 0);
    lowPhase(8, -1, len);
    check("R8 crossing at cycle 8", len, 10);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule